// File: doc/BRIEF.md
# Power-Up Reset Release Sequencer

This block decides when a small processor core may leave reset. A power-on pulse, a brown-out recovery or a wake request starts a chain of timed phases. The chain can hold a supply-settling delay, an oscillator start-up count and a PLL lock delay. Which of these run depends on configuration enables, on the oscillator mode and on what started the chain. Each phase counts qualified ticks. The supply-settling and PLL phases count ticks from a slow RC timebase. The oscillator phase counts ticks of the oscillator input. The core stays in reset until the chain reaches the run state and the synchronized external reset pin is high.

The block also filters brown-outs. A supply-good flag that stays low for a set number of RC ticks forces the brown-out state. When the supply returns, the block runs the supply-settling delay again. The time-outs run whether or not the external pin is low. If the pin is held low past the end of the chain, raising it releases the core two clocks later. A status output shows the current phase. Two sticky flags record whether the last reset came from power-on or from brown-out, and a clear input resets both.

States and transitions:
- HOLD (0) is forced by the power-on pulse. It moves to PWRUP if the delay is enabled, otherwise to the cold tail.
- PWRUP (1) moves to the cold tail when it expires if the chain is cold, otherwise to RUN.
- The cold tail is OSCST for crystal modes, else PLLLK if the PLL is enabled, else RUN.
- OSCST (2) moves to PLLLK or to RUN when it expires.
- PLLLK (3) moves to RUN when it expires.
- BROWN (4) moves to PWRUP or to RUN when the supply returns.
- RUN (5) moves to OSCST or PLLLK on a wake request.
- Any state other than HOLD and BROWN moves to BROWN on a filtered trip.

Top module: `por_reset_sequencer`

## Requirements
- R1: After the power-on pulse falls, the phases run in the fixed order PWRUP, OSCST, PLLLK, RUN. Absent phases are skipped. The phase output uses the codes HOLD=0, PWRUP=1, OSCST=2, PLLLK=3, BROWN=4, RUN=5. The osc_mode input uses the codes 0 low-power crystal, 1 standard crystal, 2 high-speed crystal, 3 RC.
- R2: PWRUP runs only when cfg_pwrt_en is 1, and only after a power-on pulse or a brown-out recovery. It lasts PWRT_TICKS rc_tick pulses and makes no progress while rc_tick is 0.
- R3: OSCST lasts OST_CYCLES osc_tick pulses (1024 by default). It runs only for osc_mode 0 to 2, and only after a power-on pulse or a wake request.
- R4: When cfg_pll_en is 1, PLLLK follows OSCST, or follows the preceding phase when there is no OSCST. It lasts PLL_TICKS rc_tick pulses and runs only after a power-on pulse or a wake request.
- R5: With ticks present every clock, core_rst falls max(1 + sum of active phase lengths, 2) clocks after the power-on pulse falls. With RC mode and every delay disabled, this gives 2 clocks.
- R6: With cfg_bor_en at 1, supply_ok held low for BOR_TICKS consecutive rc_tick pulses enters BROWN. A shorter dip has no effect. With cfg_bor_en at 0, a supply drop has no effect.
- R7: BROWN lasts until supply_ok returns. The next state is PWRUP if it is enabled, otherwise RUN. OSCST and PLLLK do not run after a brown-out.
- R8: A filtered supply drop during PWRUP returns to BROWN. The following PWRUP counts its full length again.
- R9: The phases advance while mclr_n is low. core_rst stays asserted while the synchronized pin is low and falls two clocks after mclr_n rises.
- R10: In RUN, a wake_req pulse enters OSCST for crystal modes, otherwise PLLLK if enabled. It has no effect in RC mode with the PLL disabled.
- R11: por_flag is set by the power-on pulse. bor_flag is set on entry to BROWN. cause_clr clears both, and a new set takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous reset |
| supply_ok | input | 1 | Supply-good comparator flag |
| mclr_n | input | 1 | External reset pin, active low |
| osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS crystal, 3 RC |
| cfg_pwrt_en | input | 1 | Enables the power-up delay |
| cfg_bor_en | input | 1 | Enables brown-out reset |
| cfg_pll_en | input | 1 | Enables the PLL lock delay |
| wake_req | input | 1 | Wake-from-sleep request pulse |
| rc_tick | input | 1 | Tick enable from the RC timebase |
| osc_tick | input | 1 | Tick enable from the oscillator input |
| cause_clr | input | 1 | Clears the sticky cause flags |
| core_rst | output | 1 | Holds the core in reset |
| phase | output | 3 | Current state code |
| por_flag | output | 1 | Sticky power-on cause |
| bor_flag | output | 1 | Sticky brown-out cause |

## Verification
The phase output shows the state register every clock, so a wrong transition shows up in the cycle after the edge that took it. A counter that expires early or late moves the fall of core_rst by a whole number of clocks. The bench computes that release cycle from the phase lengths for every mode and enable combination. A brown-out filter or restart fault shows up as a release that comes one full PWRUP length too soon or too late, or as a dip that changes the phase when it should not.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_PWRUP = 3'd1,
        ST_OSCST = 3'd2,
        ST_PLLLK = 3'd3,
        ST_BROWN = 3'd4,
        ST_RUN   = 3'd5
    } seq_state_e;

    localparam logic [1:0] OSC_RC_MODE = 2'd3;

    function automatic logic is_crystal(input logic [1:0] mode);
        return mode != OSC_RC_MODE;
    endfunction
endpackage

// File: rtl/rs_sync2.sv
module rs_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rs_tick_timer.sv
module rs_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == limit - W'(1));

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= cnt_q + W'(1);
    end

    // R2
    timer_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < limit));
endmodule

// File: rtl/rs_bor_filter.sv
module rs_bor_filter #(
    parameter int TRIP_TICKS = 4,
    localparam int W = $clog2(TRIP_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic supply_ok,
    input  logic tick,
    output logic trip
);
    localparam logic [W-1:0] LAST = W'(TRIP_TICKS - 1);
    logic [W-1:0] low_cnt_q;

    assign trip = en && !supply_ok && tick && (low_cnt_q == LAST);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            low_cnt_q <= '0;
        else if (!en || supply_ok)
            low_cnt_q <= '0;
        else if (tick && low_cnt_q != LAST)
            low_cnt_q <= low_cnt_q + W'(1);
    end

    // R6
    filter_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        low_cnt_q <= LAST);
endmodule

// File: rtl/por_reset_sequencer.sv
module por_reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 2,
    parameter int BOR_TICKS  = 4
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       supply_ok,
    input  logic       mclr_n,
    input  logic [1:0] osc_mode,
    input  logic       cfg_pwrt_en,
    input  logic       cfg_bor_en,
    input  logic       cfg_pll_en,
    input  logic       wake_req,
    input  logic       rc_tick,
    input  logic       osc_tick,
    input  logic       cause_clr,
    output logic       core_rst,
    output logic [2:0] phase,
    output logic       por_flag,
    output logic       bor_flag
);
    localparam int RC_MAX = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
    localparam int RC_W   = $clog2(RC_MAX + 1);
    localparam int OST_W  = $clog2(OST_CYCLES + 1);
    localparam logic [RC_W-1:0]  PWRT_LIM = RC_W'(PWRT_TICKS);
    localparam logic [RC_W-1:0]  PLL_LIM  = RC_W'(PLL_TICKS);
    localparam logic [OST_W-1:0] OST_LIM  = OST_W'(OST_CYCLES);

    seq_state_e st_q, st_d;
    logic cold_q, cold_d;
    logic por_q, bor_q;
    logic mclr_s, xtal, enter_brown;
    logic rc_run, rc_exp, osc_exp, bor_trip, phase_chg;
    logic [RC_W-1:0] rc_lim;

    function automatic seq_state_e cold_tail(input logic cold, input logic xt,
                                             input logic pll);
        if (cold && xt)
            return ST_OSCST;
        else if (cold && pll)
            return ST_PLLLK;
        else
            return ST_RUN;
    endfunction

    assign xtal      = is_crystal(osc_mode);
    assign phase_chg = (st_d != st_q);
    assign rc_run    = (st_q == ST_PWRUP) || (st_q == ST_PLLLK);
    assign rc_lim    = (st_q == ST_PLLLK) ? PLL_LIM : PWRT_LIM;

    rs_sync2 u_mclr_sync (
        .clk (clk),
        .rst (por_pulse),
        .d   (mclr_n),
        .q   (mclr_s)
    );

    rs_tick_timer #(.W(RC_W)) u_rc_timer (
        .clk    (clk),
        .rst    (por_pulse),
        .clr    (phase_chg),
        .run    (rc_run),
        .tick   (rc_tick),
        .limit  (rc_lim),
        .expire (rc_exp)
    );

    rs_tick_timer #(.W(OST_W)) u_osc_timer (
        .clk    (clk),
        .rst    (por_pulse),
        .clr    (phase_chg),
        .run    (st_q == ST_OSCST),
        .tick   (osc_tick),
        .limit  (OST_LIM),
        .expire (osc_exp)
    );

    rs_bor_filter #(.TRIP_TICKS(BOR_TICKS)) u_bor_filter (
        .clk       (clk),
        .rst       (por_pulse),
        .en        (cfg_bor_en),
        .supply_ok (supply_ok),
        .tick      (rc_tick),
        .trip      (bor_trip)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  st_d = cfg_pwrt_en ? ST_PWRUP : cold_tail(1'b1, xtal, cfg_pll_en);
            ST_PWRUP: if (rc_exp) st_d = cold_tail(cold_q, xtal, cfg_pll_en);
            ST_OSCST: if (osc_exp) st_d = cfg_pll_en ? ST_PLLLK : ST_RUN;
            ST_PLLLK: if (rc_exp) st_d = ST_RUN;
            ST_BROWN: if (supply_ok) st_d = cfg_pwrt_en ? ST_PWRUP : ST_RUN;
            ST_RUN:   if (wake_req && (xtal || cfg_pll_en))
                          st_d = xtal ? ST_OSCST : ST_PLLLK;
            default:  st_d = ST_HOLD;
        endcase
        if (bor_trip && st_q != ST_HOLD && st_q != ST_BROWN)
            st_d = ST_BROWN;
    end

    assign enter_brown = (st_d == ST_BROWN) && (st_q != ST_BROWN);

    always_comb begin
        if (enter_brown)
            cold_d = 1'b0;
        else if (st_q == ST_RUN && st_d != ST_RUN)
            cold_d = 1'b1;
        else
            cold_d = cold_q;
    end

    // state register
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) begin
            st_q   <= ST_HOLD;
            cold_q <= 1'b1;
            por_q  <= 1'b1;
            bor_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cold_q <= cold_d;
            por_q  <= por_q && !cause_clr;
            bor_q  <= enter_brown || (bor_q && !cause_clr);
        end
    end

    // outputs
    always_comb begin
        core_rst = (st_q != ST_RUN) || !mclr_s;
        phase    = st_q;
        por_flag = por_q;
        bor_flag = bor_q;
    end

    // R1
    order_after_osc_chk: assert property (@(posedge clk) disable iff (por_pulse)
        ($past(st_q) == ST_OSCST && st_q != ST_OSCST) |->
        (st_q == ST_PLLLK || st_q == ST_RUN || st_q == ST_BROWN));

    // R3
    osc_needs_crystal_chk: assert property (@(posedge clk) disable iff (por_pulse)
        (st_q == ST_OSCST && $past(st_q) != ST_OSCST) |-> ($past(osc_mode) != OSC_RC_MODE));

    // R4
    pll_needs_enable_chk: assert property (@(posedge clk) disable iff (por_pulse)
        (st_q == ST_PLLLK && $past(st_q) != ST_PLLLK) |-> $past(cfg_pll_en));

    // R6
    brown_needs_enable_chk: assert property (@(posedge clk) disable iff (por_pulse)
        (st_q == ST_BROWN && $past(st_q) != ST_BROWN) |-> $past(cfg_bor_en));

    // R11
    bor_flag_source_chk: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(bor_flag) |-> (phase == 3'd4));
endmodule

// File: tb/test_por_reset_sequencer.sv
module test_por_reset_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int P = 8;
    localparam int O = 16;
    localparam int L = 3;
    localparam int B = 3;

    logic clk = 1'b0;
    logic por_pulse = 1'b1;
    logic supply_ok = 1'b1;
    logic mclr_n = 1'b1;
    logic [1:0] osc_mode = 2'd3;
    logic cfg_pwrt_en = 1'b0;
    logic cfg_bor_en = 1'b0;
    logic cfg_pll_en = 1'b0;
    logic wake_req = 1'b0;
    logic rc_tick = 1'b1;
    logic osc_tick = 1'b1;
    logic cause_clr = 1'b0;
    logic core_rst;
    logic [2:0] phase;
    logic por_flag, bor_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    por_reset_sequencer #(
        .PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L), .BOR_TICKS(B)
    ) i_por_reset_sequencer (
        .clk(clk), .por_pulse(por_pulse), .supply_ok(supply_ok), .mclr_n(mclr_n),
        .osc_mode(osc_mode), .cfg_pwrt_en(cfg_pwrt_en), .cfg_bor_en(cfg_bor_en),
        .cfg_pll_en(cfg_pll_en), .wake_req(wake_req), .rc_tick(rc_tick),
        .osc_tick(osc_tick), .cause_clr(cause_clr), .core_rst(core_rst),
        .phase(phase), .por_flag(por_flag), .bor_flag(bor_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic power_on(input logic [1:0] m, input logic pw, input logic pl,
                            input logic bo, input logic mc);
        @(negedge clk);
        osc_mode = m; cfg_pwrt_en = pw; cfg_pll_en = pl; cfg_bor_en = bo;
        mclr_n = mc; supply_ok = 1'b1; por_pulse = 1'b1;
        repeat (3) @(negedge clk);
        por_pulse = 1'b0;
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (core_rst && n < 400);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset phase HOLD", int'(phase), 0);
        chk("R9 reset core_rst", int'(core_rst), 1);

        // R1 R2 R3 R4 R5: full sweep of mode and enables
        for (int m = 0; m < 4; m++) begin
            for (int pw = 0; pw < 2; pw++) begin
                for (int pl = 0; pl < 2; pl++) begin
                    int exp;
                    exp = 1 + (pw != 0 ? P : 0) + (m != 3 ? O : 0) + (pl != 0 ? L : 0);
                    if (exp < 2) exp = 2;
                    power_on(2'(m), 1'(pw), 1'(pl), 1'b0, 1'b1);
                    wait_release(n);
                    chk("R5 release cycle", n, exp);
                    chk("R1 run phase", int'(phase), 5);
                    chk("R11 por_flag after power-on", int'(por_flag), 1);
                end
            end
        end

        // R2: no rc ticks, no progress
        rc_tick = 1'b0;
        power_on(2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk("R2 stalled in PWRUP", int'(phase), 1);
        rc_tick = 1'b1;
        wait_release(n);
        chk("R2 PWRUP length after stall", n, P);

        // R9: time-outs run while pin is low
        power_on(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        chk("R9 phases done under pin", int'(phase), 5);
        chk("R9 still held by pin", int'(core_rst), 1);
        mclr_n = 1'b1;
        @(negedge clk);
        chk("R9 one clock after pin", int'(core_rst), 1);
        @(negedge clk);
        chk("R9 two clocks after pin", int'(core_rst), 0);

        // R6 R7 R8 R11: brown-out handling
        power_on(2'd2, 1'b1, 1'b1, 1'b1, 1'b1);
        wait_release(n);
        chk("R5 release HS+PLL", n, 1 + P + O + L);
        chk("R11 bor_flag clear", int'(bor_flag), 0);
        supply_ok = 1'b0;
        repeat (B - 1) @(negedge clk);
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 short dip phase", int'(phase), 5);
        chk("R6 short dip core_rst", int'(core_rst), 0);
        supply_ok = 1'b0;
        repeat (B - 1) @(negedge clk);
        chk("R6 before filter trip", int'(core_rst), 0);
        @(negedge clk);
        chk("R6 brown-out entered", int'(phase), 4);
        chk("R11 bor_flag set", int'(bor_flag), 1);
        repeat (5) @(negedge clk);
        chk("R7 stays in BROWN", int'(phase), 4);
        supply_ok = 1'b1;
        wait_release(n);
        chk("R7 recovery length no OSC/PLL", n, 1 + P);
        supply_ok = 1'b0;
        repeat (B + 2) @(negedge clk);
        supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 in PWRUP before re-drop", int'(phase), 1);
        supply_ok = 1'b0;
        repeat (B) @(negedge clk);
        chk("R8 re-drop returns to BROWN", int'(phase), 4);
        supply_ok = 1'b1;
        wait_release(n);
        chk("R8 full PWRUP restart", n, 1 + P);
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        chk("R11 por_flag cleared", int'(por_flag), 0);
        chk("R11 bor_flag cleared", int'(bor_flag), 0);

        // R6: brown-out disabled
        power_on(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        wait_release(n);
        supply_ok = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 disabled phase", int'(phase), 5);
        chk("R6 disabled core_rst", int'(core_rst), 0);
        supply_ok = 1'b1;

        // R10: wake in crystal mode with PLL
        power_on(2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        wait_release(n);
        chk("R5 release XT+PLL", n, 1 + O + L);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R10 wake enters OSCST", int'(phase), 2);
        wait_release(n);
        chk("R10 wake sequence length", n, O + L);

        // R10: wake ignored in RC without PLL
        power_on(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        wait_release(n);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 RC wake phase", int'(phase), 5);
        chk("R10 RC wake core_rst", int'(core_rst), 0);

        finish_run();
    end
endmodule